// File: doc/BRIEF.md
# Page Table Address Translation Unit

This block turns a virtual address into a physical address. It looks up a single-level page table that sits in a small local memory. Software sets two registers: a table base, which is the first table slot of the current address space, and a table limit, which is the highest legal virtual page number. Each request carries a virtual address and two qualifiers: whether the access is a write, and whether it comes from privileged code. The unit returns either a physical address or a fault code.

The virtual address splits into a 20-bit virtual page number above a 12-bit page offset. The page number is first compared with the limit. When it is in range, the page number is added to the base, and the sum selects a table entry. One entry carries a present flag, three permission flags and a 16-bit physical page number. The permission check runs in the same step that builds the physical address, so a request yields one answer: a bounds fault, a missing-page fault, a protection fault, or a translation.

Requests and responses each use a valid/ready handshake. The unit holds one request at a time. The table has a separate write port that software uses to load entries.

Top module: `ptw_xlate_unit`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1 and rsp_valid is 0, and both the base and the limit registers read as 0.
- R2: On a successful translation, rsp_paddr equals the entry's physical page number (bits 15:0) concatenated above req_vaddr[11:0], and rsp_fault is 0.
- R3: The entry index is (base + low 8 bits of the virtual page number) modulo 256, so an index past the top of the table wraps around to the bottom.
- R4: When the virtual page number req_vaddr[31:12] is greater than the limit, rsp_fault is 1 (bounds) whatever the table holds. A page number equal to the limit is legal.
- R5: An in-range entry whose present flag (bit 19) is 0 gives rsp_fault 2 (page fault).
- R6: A write to an entry without the writable flag (bit 17), or a read of an entry without the readable flag (bit 18), gives rsp_fault 3 (protection).
- R7: An entry with the supervisor-only flag (bit 16) gives rsp_fault 3 when req_priv is 0, and translates normally when req_priv is 1.
- R8: When several faults apply, bounds outranks page fault, and page fault outranks protection.
- R9: rsp_valid rises two clock edges after the edge that accepts a request. req_ready stays 0 from acceptance until the response has been taken.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_paddr and rsp_fault stay unchanged.
- R11: Whenever rsp_fault is not 0, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for a control register |
| cfg_sel | input | 1 | Register select: 0 selects the table base, 1 selects the limit |
| cfg_wdata | input | 20 | Register write value (the base uses the low 8 bits) |
| pte_we | input | 1 | Table entry write strobe |
| pte_waddr | input | 8 | Table slot to write |
| pte_wdata | input | 20 | Entry: 19 present, 18 readable, 17 writable, 16 supervisor-only, 15:0 physical page |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write (0 means read) |
| req_priv | input | 1 | Access comes from privileged code |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 28 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 page fault, 3 protection |

## Verification
A vector table sweeps pages that are built to isolate each check in turn:
- a fully permitted page, which shows that the page number and the offset are joined correctly;
- a read-only page and a write-only page, each tried with both access types, which separates the read permission from the write permission;
- a supervisor-only page, tried with and without privilege;
- an absent page that also lacks write permission, which shows the page fault outranking protection;
- page numbers just above the limit and far above it, with a valid entry planted where the out-of-range page would index, which shows that the limit wins over the table contents;
- a page number equal to the limit, which pins the boundary as inclusive.

Directed tests follow:
- a base near the top of the table, which exercises index wrap-around;
- a tightened limit over an absent page, which shows bounds outranking a page fault;
- a held response under backpressure;
- a second reset, which shows the limit returning to 0.

// File: rtl/ptw_pkg.sv
// Package ptw_pkg: types and flag positions shared by the translation unit.
// Assumes a table entry is {present, readable, writable, supervisor-only, ppn}.
package ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BOUNDS = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PERM   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } xl_state_e;

    // Flag positions counted upward from the top of the physical page field.
    localparam int FLG_SUP = 0;
    localparam int FLG_WR  = 1;
    localparam int FLG_RD  = 2;
    localparam int FLG_PRS = 3;
    localparam int FLG_N   = 4;

endpackage

// File: rtl/ptw_index_gen.sv
// Module ptw_index_gen: compares the virtual page number with the limit and
// forms the table index as base plus page number, modulo the table depth.
// Assumes the depth is a power of two, so dropping the carry wraps the index.
module ptw_index_gen #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 8
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [IDX_W-1:0] base,
    input  logic [VPN_W-1:0] limit,
    output logic [IDX_W-1:0] idx,
    output logic             oob
);

    // Range check and wrapped index sum.
    always_comb begin
        oob = (vpn > limit);
        idx = base + vpn[IDX_W-1:0];
    end

endmodule

// File: rtl/ptw_pte_store.sv
// Module ptw_pte_store: page table memory with one write port and one
// registered read port. Assumes software loads entries before they are used.
// The array has no reset because it is a memory.
module ptw_pte_store #(
    parameter int DEPTH = 256,
    parameter int ENT_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);

    logic [ENT_W-1:0] mem [DEPTH];

    // Entry load from software.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered lookup, enabled only for in-range requests.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/ptw_perm_check.sv
// Module ptw_perm_check: chooses the fault code by priority and builds the
// physical address from a fetched entry.
// Assumes the bounds flag was captured when the request was accepted.
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PPN_W = 16,
    localparam int ENT_W = PPN_W + FLG_N,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             oob,
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_priv,
    input  logic [OFF_W-1:0] offset,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);

    logic present, can_rd, can_wr, sup_only, denied;

    // Split the entry into its flags.
    always_comb begin
        present  = entry[PPN_W + FLG_PRS];
        can_rd   = entry[PPN_W + FLG_RD];
        can_wr   = entry[PPN_W + FLG_WR];
        sup_only = entry[PPN_W + FLG_SUP];
        denied   = (is_write ? !can_wr : !can_rd) || (sup_only && !is_priv);
    end

    // Priority: bounds, then absent page, then permission.
    always_comb begin
        if (oob) begin
            fault = FLT_BOUNDS;
        end else if (!present) begin
            fault = FLT_ABSENT;
        end else if (denied) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
        paddr = (fault == FLT_NONE) ? {entry[PPN_W-1:0], offset} : '0;
    end

endmodule

// File: rtl/ptw_xlate_unit.sv
// Module ptw_xlate_unit: single-level page table translation with a limit
// check, page-level permissions and valid/ready on both sides.
// Assumes one request in flight and control register writes while idle.
// The response appears two edges after acceptance: one edge reads the table,
// the next registers the checked result.
module ptw_xlate_unit
    import ptw_pkg::*;
#(
    parameter int OFF_W     = 12,
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 16,
    parameter int TBL_DEPTH = 256,
    localparam int IDX_W = $clog2(TBL_DEPTH),
    localparam int ENT_W = PPN_W + FLG_N,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [VPN_W-1:0] cfg_wdata,
    input  logic             pte_we,
    input  logic [IDX_W-1:0] pte_waddr,
    input  logic [ENT_W-1:0] pte_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_priv,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault
);

    xl_state_e        state_q;
    logic [IDX_W-1:0] base_q;
    logic [VPN_W-1:0] limit_q;
    logic             oob_q, wr_q, priv_q;
    logic [OFF_W-1:0] off_q;
    logic             rsp_valid_q;
    logic [PA_W-1:0]  rsp_paddr_q;
    fault_e           rsp_fault_q;

    logic             accept;
    logic [IDX_W-1:0] tbl_idx;
    logic             req_oob;
    logic [ENT_W-1:0] tbl_entry;
    fault_e           chk_fault;
    logic [PA_W-1:0]  chk_paddr;

    // Handshake on the request side.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    ptw_index_gen #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_idx (
        .vpn   (req_vaddr[VA_W-1:OFF_W]),
        .base  (base_q),
        .limit (limit_q),
        .idx   (tbl_idx),
        .oob   (req_oob)
    );

    ptw_pte_store #(.DEPTH(TBL_DEPTH), .ENT_W(ENT_W)) u_tbl (
        .clk   (clk),
        .we    (pte_we),
        .waddr (pte_waddr),
        .wdata (pte_wdata),
        .re    (accept && !req_oob),
        .raddr (tbl_idx),
        .rdata (tbl_entry)
    );

    ptw_perm_check #(.OFF_W(OFF_W), .PPN_W(PPN_W)) u_chk (
        .oob      (oob_q),
        .entry    (tbl_entry),
        .is_write (wr_q),
        .is_priv  (priv_q),
        .offset   (off_q),
        .fault    (chk_fault),
        .paddr    (chk_paddr)
    );

    // Control register writes from software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                limit_q <= cfg_wdata;
            end else begin
                base_q <= cfg_wdata[IDX_W-1:0];
            end
        end
    end

    // Request capture, result registration and response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_paddr_q <= '0;
            rsp_fault_q <= FLT_NONE;
            oob_q       <= 1'b0;
            wr_q        <= 1'b0;
            priv_q      <= 1'b0;
            off_q       <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        oob_q   <= req_oob;
                        wr_q    <= req_write;
                        priv_q  <= req_priv;
                        off_q   <= req_vaddr[OFF_W-1:0];
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    rsp_fault_q <= chk_fault;
                    rsp_paddr_q <= chk_paddr;
                    rsp_valid_q <= 1'b1;
                    state_q     <= ST_RESP;
                end
                ST_RESP: begin
                    if (rsp_ready) begin
                        rsp_valid_q <= 1'b0;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_paddr = rsp_paddr_q;
    assign rsp_fault = rsp_fault_q;

    AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R10
    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9
    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid); // R9
    AST_BOUNDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_vaddr[VA_W-1:OFF_W] > limit_q)) |-> ##2 (rsp_fault == 2'd1)); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 ((rsp_fault != 2'd0) || (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0], 2)))); // R2
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != 2'd0)) |-> (rsp_paddr == '0)); // R11

endmodule

// File: tb/sim_ptw_xlate_unit.sv
// Bench for ptw_xlate_unit: a vector table walked by one loop, then directed
// tests for reset, index wrap, fault priority and backpressure.
module sim_ptw_xlate_unit;

    localparam logic [19:0] P_V = 20'h80000;
    localparam logic [19:0] P_R = 20'h40000;
    localparam logic [19:0] P_W = 20'h20000;
    localparam logic [19:0] P_S = 20'h10000;

    // Vector: {vaddr[31:0], write, priv, fault[1:0], paddr[27:0], req[3:0]}
    localparam int NV = 12;
    localparam logic [67:0] VEC [NV] = '{
        {32'h00001123, 1'b0, 1'b0, 2'd0, 28'hABCD123, 4'd2},   // R2 full rights
        {32'h000020FF, 1'b1, 1'b0, 2'd3, 28'h0,       4'd6},   // R6 write to read-only
        {32'h000020FF, 1'b0, 1'b0, 2'd0, 28'h11110FF, 4'd2},   // R2 read of read-only
        {32'h00003000, 1'b1, 1'b0, 2'd2, 28'h0,       4'd8},   // R8 absent beats perm (R5)
        {32'h00004ABC, 1'b0, 1'b0, 2'd3, 28'h0,       4'd7},   // R7 user on sup page
        {32'h00004ABC, 1'b0, 1'b1, 2'd0, 28'h2222ABC, 4'd7},   // R7 priv on sup page
        {32'h00005001, 1'b0, 1'b1, 2'd3, 28'h0,       4'd6},   // R6 read of write-only
        {32'h00005001, 1'b1, 1'b0, 2'd0, 28'h3333001, 4'd6},   // R6 write of write-only
        {32'h00041777, 1'b0, 1'b1, 2'd1, 28'h0,       4'd4},   // R4 just past limit
        {32'h00040FFF, 1'b0, 1'b0, 2'd0, 28'h4444FFF, 4'd4},   // R4 equal to limit
        {32'hFFFFF000, 1'b1, 1'b0, 2'd1, 28'h0,       4'd4},   // R4 far past limit
        {32'h00006555, 1'b0, 1'b0, 2'd0, 28'hFFFF555, 4'd2}    // R2 top page number
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic        pte_we = 1'b0;
    logic [7:0]  pte_waddr = '0;
    logic [19:0] pte_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [27:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ptw_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pte_we(pte_we), .pte_waddr(pte_waddr), .pte_wdata(pte_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_cfg(input bit sel, input logic [19:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_pte(input logic [7:0] idx, input logic [19:0] val);
        @(negedge clk);
        pte_we = 1'b1; pte_waddr = idx; pte_wdata = val;
        @(negedge clk);
        pte_we = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input bit wr, input bit pv,
                         input logic [1:0] ef, input logic [27:0] ep,
                         input string rq, input int hold);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_priv = pv; req_valid = 1'b1; rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!rsp_valid && !req_ready, "R9 busy after accept", {rsp_valid, req_ready}, 32'h0);
        @(negedge clk);
        chk(rsp_valid, "R9 response two edges after accept", rsp_valid, 32'h1);
        chk(rsp_fault == ef, {rq, " fault"}, rsp_fault, ef);
        chk(rsp_paddr == ep, {rq, " paddr"}, rsp_paddr, ep);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_fault == ef && rsp_paddr == ep, "R10 held under backpressure",
                {rsp_valid, rsp_fault, rsp_paddr}, {1'b1, ef, ep});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9 idle after response taken", {rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset state", {req_ready, rsp_valid}, 32'h2);

        // Table for the vector walk: base 16, limit 0x40.
        set_cfg(1'b0, 20'd16);
        set_cfg(1'b1, 20'h00040);
        put_pte(8'd17, P_V | P_R | P_W | 20'hABCD);
        put_pte(8'd18, P_V | P_R | 20'h1111);
        put_pte(8'd19, 20'h0);
        put_pte(8'd20, P_V | P_R | P_W | P_S | 20'h2222);
        put_pte(8'd21, P_V | P_W | 20'h3333);
        put_pte(8'd22, P_V | P_R | 20'hFFFF);
        put_pte(8'h50, P_V | P_R | 20'h4444);
        put_pte(8'h51, P_V | P_R | P_W | 20'h9999);

        for (int i = 0; i < NV; i++) begin
            xlate(VEC[i][67:36], VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:4],
                  $sformatf("R%0d vector %0d", VEC[i][3:0], i), 0);
        end

        // R10: response held for three cycles of backpressure.
        xlate(32'h00001FED, 1'b1, 1'b0, 2'd0, 28'hABCDFED, "R10 backpressure", 3);

        // R3: base near the top wraps the index.
        set_cfg(1'b0, 20'h000F8);
        set_cfg(1'b1, 20'hFFFFF);
        put_pte(8'h02, P_V | P_R | 20'h5555);
        put_pte(8'hF8, P_V | P_R | 20'h6666);
        xlate(32'h0000A321, 1'b0, 1'b0, 2'd0, 28'h5555321, "R3 wrapped index", 0);
        xlate(32'h00000040, 1'b0, 1'b0, 2'd0, 28'h6666040, "R3 base slot", 0);

        // R8: bounds beats an absent page (vpn 3 is absent at base 16).
        set_cfg(1'b0, 20'd16);
        set_cfg(1'b1, 20'h00002);
        xlate(32'h00003000, 1'b0, 1'b0, 2'd1, 28'h0, "R8 bounds over absent", 0);

        // R1: a second reset clears the limit to 0.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        xlate(32'h00001000, 1'b0, 1'b1, 2'd1, 28'h0, "R1 limit cleared by reset", 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule